// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and drives two processor request outputs from them: a normal-priority request and a fast request. One raw level vector feeds both outputs. Each output has its own enable mask, so a source can reach the normal output, the fast output, both, or neither. Software changes a mask only through a pair of registers. One register turns on the bits written as 1, and the other turns off the bits written as 1. No read-modify-write is needed.

Software can also raise a request on its own. A latch written through two further registers is ORed into source 0. Software reads the raw levels, the masked status of each output and both masks through word-addressed registers on a 32-bit bus. Read data is registered and appears one cycle after the read strobe.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Raw status bit n equals input line n for every n greater than 0. Raw bit 0 equals input line 0 OR the software latch. The raw vector reads back at word 1 and again at word 9.
- R2: The normal output is registered. It is high in the cycle after (raw AND normal mask) is non-zero, and low in the cycle after that term is zero.
- R3: The fast output follows the same rule using (raw AND fast mask).
- R4: A write to word 2 sets every normal-mask bit written as 1. A write to word 3 clears every normal-mask bit written as 1. Bits written as 0 are left unchanged. Word 2 reads back the normal mask.
- R5: Words 10 and 11 set and clear the fast mask in the same way as R4. Word 10 reads back the fast mask.
- R6: A write to word 4 with data bit 0 set turns the software latch on. The same write to word 5 turns it off. All other data bits are ignored. A change on input line 0 leaves the latch unchanged.
- R7: A read of word 4 returns raw bit 0 in data bit 0 and zero in every other bit.
- R8: Word 0 reads (raw AND normal mask). Word 8 reads (raw AND fast mask).
- R9: Reads of words 3, 5 and 11, and of any unlisted word, return 0.
- R10: Writes to words 0, 1, 8 and 9 change neither mask and do not change the software latch.
- R11: After synchronous reset, both masks and the software latch are 0, both outputs are low and the read data is 0.
- R12: Read data updates on the clock edge where the read strobe is high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC (32) | Level interrupt lines |
| addr_i | input | AW (6) | Word address shared by reads and writes |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DW (32) | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DW (32) | Registered read data |
| irq_o | output | 1 | Normal-priority request |
| fiq_o | output | 1 | Fast request |

## Verification
The bench builds the block with its default parameters: 32 sources, a 32-bit data bus and a 6-bit word address. With these values every source bit, including the top bit, can be driven and masked. Addresses beyond word 11 can also be probed for the zero-read rule. A vector table and a seeded random sequence drive mask set and clear operations, software latch operations and input patterns together. The bench compares both outputs and the status words against its own model. Directed steps then cover reset, the persistence of the software latch while input line 0 toggles, the ignored data bits, and the read-only and write-only words.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NCH       = 2;
  localparam int unsigned CH_STRIDE = 8;
  localparam int unsigned W_STAT    = 0;
  localparam int unsigned W_RAW     = 1;
  localparam int unsigned W_ENSET   = 2;
  localparam int unsigned W_ENCLR   = 3;
  localparam int unsigned W_SWSET   = 4;
  localparam int unsigned W_SWCLR   = 5;
endpackage

// File: rtl/irqc_mask.sv
module irqc_mask #(
  parameter int unsigned NSRC     = 32,
  parameter int unsigned AW       = 6,
  parameter int unsigned SET_WORD = 2,
  parameter int unsigned CLR_WORD = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] en_q
);
  localparam logic [AW-1:0] SET_A = AW'(SET_WORD);
  localparam logic [AW-1:0] CLR_A = AW'(CLR_WORD);

  logic do_set, do_clr;
  assign do_set = wr_en && (addr == SET_A);
  assign do_clr = wr_en && (addr == CLR_A);

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (do_set) en_q <= en_q | wdata;
    else if (do_clr) en_q <= en_q & ~wdata;
  end

  // R4 / R5: set writes add bits, clear writes remove bits
  a_r4_set_adds: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SET_A) |=> ((en_q & $past(wdata)) == $past(wdata)));
  a_r4_clr_removes: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CLR_A) |=> ((en_q & $past(wdata)) == '0));
  a_r5_keep_other: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SET_A) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
endmodule

// File: rtl/irqc_raw.sv
module irqc_raw #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic            wbit0,
  input  logic [NSRC-1:0] src,
  output logic            sw_q,
  output logic [NSRC-1:0] raw
);
  import irqc_pkg::*;
  localparam logic [AW-1:0] SWSET_A = AW'(W_SWSET);
  localparam logic [AW-1:0] SWCLR_A = AW'(W_SWCLR);

  always_ff @(posedge clk) begin
    if (rst) sw_q <= 1'b0;
    else if (wr_en && wbit0 && addr == SWSET_A) sw_q <= 1'b1;
    else if (wr_en && wbit0 && addr == SWCLR_A) sw_q <= 1'b0;
  end

  always_comb begin
    raw    = src;
    raw[0] = src[0] | sw_q;
  end

  // R6: latch set / clear / ignored data bits
  a_r6_sw_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wbit0 && addr == SWSET_A) |=> sw_q);
  a_r6_sw_clr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wbit0 && addr == SWCLR_A) |=> !sw_q);
  a_r6_sw_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wbit0 && (addr == SWSET_A || addr == SWCLR_A)) |=> $stable(sw_q));
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] en,
  output logic            line_q
);
  logic hit;
  assign hit = |(raw & en);

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= hit;
  end

  // R2 / R3: output follows masked raw one cycle later
  a_r2_rise: assert property (@(posedge clk) disable iff (rst)
    (|(raw & en)) |=> line_q);
  a_r3_fall: assert property (@(posedge clk) disable iff (rst)
    !(|(raw & en)) |=> !line_q);
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] en_n,
  input  logic [NSRC-1:0] en_f,
  output logic [DW-1:0]   rd_q
);
  import irqc_pkg::*;
  localparam logic [AW-1:0] A_NSTAT = AW'(W_STAT);
  localparam logic [AW-1:0] A_NRAW  = AW'(W_RAW);
  localparam logic [AW-1:0] A_NEN   = AW'(W_ENSET);
  localparam logic [AW-1:0] A_SW    = AW'(W_SWSET);
  localparam logic [AW-1:0] A_FSTAT = AW'(CH_STRIDE + W_STAT);
  localparam logic [AW-1:0] A_FRAW  = AW'(CH_STRIDE + W_RAW);
  localparam logic [AW-1:0] A_FEN   = AW'(CH_STRIDE + W_ENSET);

  logic [NSRC-1:0] sel;
  logic [DW-1:0]   nxt;

  always_comb begin
    sel = '0;
    unique case (addr)
      A_NSTAT: sel = raw & en_n;
      A_NRAW:  sel = raw;
      A_NEN:   sel = en_n;
      A_SW:    sel[0] = raw[0];
      A_FSTAT: sel = raw & en_f;
      A_FRAW:  sel = raw;
      A_FEN:   sel = en_f;
      default: sel = '0;
    endcase
    nxt = '0;
    nxt[NSRC-1:0] = sel;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= nxt;
  end

  // R9: write-only word reads as zero
  a_r9_wo_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(W_ENCLR)) |=> (rd_q == '0));
  // R7: software word carries only bit 0
  a_r7_sw_word: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_SW) |=> (rd_q[DW-1:1] == '0));
  // R12: data holds without a strobe
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            rd_en_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            irq_o,
  output logic            fiq_o
);
  import irqc_pkg::*;

  logic [NSRC-1:0] raw;
  logic            sw_q;
  logic [NSRC-1:0] en   [NCH];
  logic            line [NCH];

  irqc_raw #(.NSRC(NSRC), .AW(AW)) u_raw (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .addr(addr_i),
    .wbit0(wr_data_i[0]), .src(src_i), .sw_q(sw_q), .raw(raw)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    irqc_mask #(
      .NSRC(NSRC), .AW(AW),
      .SET_WORD(ch * CH_STRIDE + W_ENSET),
      .CLR_WORD(ch * CH_STRIDE + W_ENCLR)
    ) u_mask (
      .clk(clk), .rst(rst), .wr_en(wr_en_i), .addr(addr_i),
      .wdata(wr_data_i[NSRC-1:0]), .en_q(en[ch])
    );
    irqc_gate #(.NSRC(NSRC)) u_gate (
      .clk(clk), .rst(rst), .raw(raw), .en(en[ch]), .line_q(line[ch])
    );
  end

  irqc_rdmux #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en_i), .addr(addr_i),
    .raw(raw), .en_n(en[0]), .en_f(en[1]), .rd_q(rd_data_o)
  );

  assign irq_o = line[0];
  assign fiq_o = line[1];

  logic ro_wr;
  assign ro_wr = wr_en_i && (addr_i == AW'(W_STAT) || addr_i == AW'(W_RAW) ||
                 addr_i == AW'(CH_STRIDE + W_STAT) || addr_i == AW'(CH_STRIDE + W_RAW));

  // R10: writes to status words change nothing
  a_r10_ro_write: assert property (@(posedge clk) disable iff (rst)
    ro_wr |=> ($stable(en[0]) && $stable(en[1]) && $stable(sw_q)));
  // R1: raw bit 0 set whenever the latch is on
  a_r1_raw0: assert property (@(posedge clk) disable iff (rst)
    sw_q |-> raw[0]);
endmodule

// File: tb/dual_irq_ctrl_tb.sv
module dual_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic [AW-1:0]   addr_i = '0;
  logic            wr_en_i = 1'b0;
  logic [DW-1:0]   wr_data_i = '0;
  logic            rd_en_i = 1'b0;
  logic [DW-1:0]   rd_data_o;
  logic            irq_o, fiq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_ctrl #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .src_i(src_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [5:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{32'h0000_0000, 6'd2,  32'h0000_00F0},
    '{32'h0000_0010, 6'd10, 32'h8000_0000},
    '{32'h8000_0000, 6'd1,  32'hFFFF_FFFF},
    '{32'h8000_0000, 6'd3,  32'h0000_0010},
    '{32'h0000_0020, 6'd2,  32'h0000_0020},
    '{32'h0000_0020, 6'd4,  32'hFFFF_FFFF},
    '{32'h0000_0000, 6'd10, 32'h0000_0001},
    '{32'h0000_0000, 6'd5,  32'h0000_0001},
    '{32'h0000_0001, 6'd11, 32'hFFFF_FFFF},
    '{32'h0000_0001, 6'd2,  32'h0000_0001},
    '{32'h0F0F_0F0F, 6'd9,  32'h0000_0000},
    '{32'h0F0F_0F0F, 6'd3,  32'hFFFF_FFFF}
  };

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_en_n = '0, m_en_f = '0;
  logic        m_sw = 1'b0;
  logic [31:0] rv;

  function automatic logic [31:0] m_raw(input logic [31:0] s);
    return s | {31'b0, m_sw};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input logic [5:0] a, input logic [31:0] d);
    case (a)
      6'd2:  m_en_n = m_en_n | d;
      6'd3:  m_en_n = m_en_n & ~d;
      6'd10: m_en_f = m_en_f | d;
      6'd11: m_en_f = m_en_f & ~d;
      6'd4:  if (d[0]) m_sw = 1'b1;
      6'd5:  if (d[0]) m_sw = 1'b0;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] r;
    r = m_raw(src_i);
    chk({tag, " R2 irq"}, {31'b0, irq_o}, {31'b0, |(r & m_en_n)});
    chk({tag, " R3 fiq"}, {31'b0, fiq_o}, {31'b0, |(r & m_en_f)});
    rd(6'd0, rv);  chk({tag, " R8 word0"}, rv, r & m_en_n);
    rd(6'd8, rv);  chk({tag, " R8 word8"}, rv, r & m_en_f);
    rd(6'd1, rv);  chk({tag, " R1 word1"}, rv, r);
    rd(6'd2, rv);  chk({tag, " R4 word2"}, rv, m_en_n);
    rd(6'd10, rv); chk({tag, " R5 word10"}, rv, m_en_f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R11: reset state
    chk("R11 irq", {31'b0, irq_o}, 32'd0);
    chk("R11 fiq", {31'b0, fiq_o}, 32'd0);
    chk("R11 rd_data", rd_data_o, 32'd0);
    rd(6'd2, rv);  chk("R11 normal mask", rv, 32'd0);
    rd(6'd10, rv); chk("R11 fast mask", rv, 32'd0);
    rd(6'd4, rv);  chk("R11 sw latch", rv, 32'd0);

    // Table walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) src_i = VEC[i].src;
      wr(VEC[i].addr, VEC[i].data);
      @(negedge clk);
      check_all("table");
    end

    // Random sequences
    for (int i = 0; i < 60; i++) begin
      logic [5:0] a;
      int k;
      k = $urandom_range(0, 7);
      case (k)
        0: a = 6'd2;  1: a = 6'd3;  2: a = 6'd10; 3: a = 6'd11;
        4: a = 6'd4;  5: a = 6'd5;  6: a = 6'd0;  default: a = 6'd9;
      endcase
      @(negedge clk) src_i = $urandom() & $urandom();
      wr(a, $urandom());
      @(negedge clk);
      check_all("random");
    end

    // R6: latch survives input line 0 toggling; ignored data bits
    wr(6'd5, 32'h1);
    wr(6'd3, 32'hFFFF_FFFF);
    wr(6'd11, 32'hFFFF_FFFF);
    @(negedge clk) src_i = '0;
    wr(6'd4, 32'hFFFF_FFFE);
    rd(6'd4, rv); chk("R6 ignored bits on set", rv, 32'd0);
    wr(6'd4, 32'h1);
    @(negedge clk) src_i = 32'h1;
    @(negedge clk) src_i = 32'h0;
    @(negedge clk);
    rd(6'd1, rv); chk("R6 latch persists", rv, 32'h1);
    wr(6'd5, 32'hFFFF_FFFE);
    rd(6'd4, rv); chk("R6 ignored bits on clear", rv, 32'h1);
    // R7: word 4 returns only raw bit 0
    @(negedge clk) src_i = 32'hFFFF_FFFE;
    rd(6'd4, rv); chk("R7 sw word", rv, 32'h1);
    wr(6'd5, 32'h1);
    rd(6'd4, rv); chk("R6 latch cleared", rv, 32'h0);
    @(negedge clk) src_i = 32'hFFFF_FFFF;
    rd(6'd4, rv); chk("R7 from line", rv, 32'h1);

    // R9: write-only and unmapped words
    wr(6'd2, 32'hFFFF_FFFF);
    wr(6'd10, 32'hFFFF_FFFF);
    rd(6'd3, rv);  chk("R9 word3", rv, 32'd0);
    rd(6'd5, rv);  chk("R9 word5", rv, 32'd0);
    rd(6'd11, rv); chk("R9 word11", rv, 32'd0);
    rd(6'd6, rv);  chk("R9 word6", rv, 32'd0);
    rd(6'd63, rv); chk("R9 word63", rv, 32'd0);

    // R10: read-only words ignore writes
    wr(6'd3, 32'hFFFF_0000);
    wr(6'd11, 32'h0000_FFFF);
    foreach (VEC[i]) if (i < 4) wr(i < 2 ? 6'(i) : 6'(i + 6), 32'h0000_0000);
    rd(6'd2, rv);  chk("R10 normal mask", rv, 32'h0000_FFFF);
    rd(6'd10, rv); chk("R10 fast mask", rv, 32'hFFFF_0000);
    rd(6'd4, rv);  chk("R10 latch via raw0", rv, 32'h1);

    // R12: read data holds without strobe
    rd(6'd10, rv);
    @(negedge clk) addr_i = 6'd2;
    @(negedge clk);
    chk("R12 hold", rd_data_o, 32'hFFFF_0000);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule